// File: doc/BRIEF.md
# Four-Level Nested Interrupt Controller

This block is the interrupt controller of a small 8-bit processor core. It keeps sixteen request flags and folds them into seven interrupt sources: two external pins, two timer overflows, a serial group, a general-purpose group and a comparator. The sources on the external pins can each work in edge mode or level mode. Each source has its own enable, and one global enable masks them all. Six of the sources take a two-bit priority level. The comparator always sits at the lowest level.

The core raises `instr_end` at each instruction boundary. When a request is eligible at that point, the block arbitrates and pulses `irq_take` one cycle later, together with the 16-bit handler vector. It then holds that vector until the core strobes `irq_ack`. On acknowledge, the block marks the winner's level as in service and clears the winner's flag where hardware clearing applies. A `reti` pulse retires the innermost active level. Software can set and clear flags through per-bit strobes, and the flags are visible on a read-back port.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset all sixteen flags read 0, `irq_take` is low and no level is in service.
- R2: With `ext_mode[e]`=1 (edge), a high-to-low change of `ext_pin_n[e]` sets flag 2*e on the third rising edge after the pin changes. The flag then holds after the pin returns high, until an acknowledge of that source or a software clear.
- R3: With `ext_mode[e]`=0 (level), flag 2*e shows the inverted pin, delayed by the same three edges. Software strobes and acknowledges do not change it.
- R4: `tmr_roll[t]` sets flag 1 (t=0) or flag 3 (t=1), and acknowledging that source clears the flag.
- R5: Source 4 requests while any of flags 4 (receive), 5 (transmit) or 6 (SPI) is set. Source 5 requests while any of flags 15..8 (general-purpose) is set. Source 6 requests on flag 7 (comparator). Acknowledging sources 4 to 6 clears none of these flags.
- R6: A `sw_set` or `sw_clr` bit sets or clears the matching flag on the next edge. `sw_set` has no effect on flag 6 or flags 15..8. A hardware set wins over a clear in the same cycle.
- R7: A source is taken only while both `glb_en` and its `src_en` bit are 1.
- R8: The level of source i (0..5) is {`prio_hi[i]`,`prio_lo[i]`}, where 3 is the highest. Source 6 is always level 0. Among eligible requests the highest level wins.
- R9: On equal level the lower source index wins. The vector is 0x0003 + 8*index: INT0 0x0003, T0 0x000B, INT1 0x0013, T1 0x001B, serial 0x0023, general 0x002B, comparator 0x0033.
- R10: `irq_take` is a one-cycle pulse, one cycle after an `instr_end` cycle. No further take happens until `irq_ack`.
- R11: A request is taken only if its level is strictly above the highest level in service. While level 3 is in service, nothing is taken.
- R12: `reti` clears the highest in-service level. After that, a request at a level above the new highest level can be taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_end | input | 1 | Instruction boundary, arbitration point |
| irq_ack | input | 1 | Core has entered the handler for the held vector |
| reti | input | 1 | Return from the current handler |
| glb_en | input | 1 | Global interrupt enable |
| src_en | input | 7 | Per-source enable, index = source |
| prio_lo | input | 6 | Low priority bit, sources 0..5 |
| prio_hi | input | 6 | High priority bit, sources 0..5 |
| ext_mode | input | 2 | 1 = edge mode, 0 = level mode, per external pin |
| ext_pin_n | input | 2 | Asynchronous external request pins, active low |
| tmr_roll | input | 2 | Timer rollover pulses |
| ser_rx_evt | input | 1 | Receive-complete pulse (flag 4) |
| ser_tx_evt | input | 1 | Transmit-complete pulse (flag 5) |
| spi_evt | input | 1 | SPI transfer-complete pulse (flag 6) |
| gp_evt | input | 8 | General-purpose event pulses (flags 15..8) |
| cmp_evt | input | 1 | Comparator event pulse (flag 7) |
| sw_set | input | 16 | Software set strobes per flag |
| sw_clr | input | 16 | Software clear strobes per flag |
| flags | output | 16 | Current flag values |
| irq_take | output | 1 | Interrupt taken pulse |
| irq_vec | output | 16 | Handler vector, held until acknowledge |

## Verification
Flag updates from events, strobes and acknowledges are due on the first rising edge after the cycle in which they are driven. Pin changes take three edges. A take is due on the edge after `instr_end`. The bench drives inputs on the falling edge and compares on the following falling edge: the edge-mode checks look just before and just after the third edge, and the take checks sample exactly one edge after the boundary. A behavioural model advances on every rising edge and is compared with `flags`, `irq_take` and `irq_vec` on every falling edge.

// File: rtl/nic_pkg.sv
package nic_pkg;
  localparam int NSRC   = 7;
  localparam int NPRIO  = 6;
  localparam int NFLAG  = 16;
  localparam int NLVL   = 4;
  localparam int LVLW   = $clog2(NLVL);
  localparam int IDXW   = $clog2(NSRC);
  localparam int VECW   = 16;
  localparam int NGP    = 8;
  // flag positions
  localparam int F_IE0  = 0;
  localparam int F_TF0  = 1;
  localparam int F_IE1  = 2;
  localparam int F_TF1  = 3;
  localparam int F_RX   = 4;
  localparam int F_TX   = 5;
  localparam int F_SPI  = 6;
  localparam int F_CMP  = 7;
  localparam int F_GP   = 8;
  localparam logic [VECW-1:0] VEC_BASE = 16'h0003;

  typedef logic [LVLW-1:0] lvl_t;

  function automatic logic [VECW-1:0] vec_of(input logic [IDXW-1:0] idx);
    return VEC_BASE + VECW'({idx, 3'b000});
  endfunction
endpackage

// File: rtl/nic_pin_sync.sv
module nic_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic lvl_n,
  output logic fall
);
  logic [STAGES:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[STAGES-1:0], pin_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= sh_d;
  end

  assign lvl_n = sh_q[STAGES-1];
  assign fall  = sh_q[STAGES] & ~sh_q[STAGES-1];
endmodule

// File: rtl/nic_flags.sv
module nic_flags
  import nic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       ext_edge,
  input  logic [1:0]       ext_lvl_n,
  input  logic [1:0]       ext_fall,
  input  logic [1:0]       tmr_roll,
  input  logic             rx_evt,
  input  logic             tx_evt,
  input  logic             spi_evt,
  input  logic [NGP-1:0]   gp_evt,
  input  logic             cmp_evt,
  input  logic [NFLAG-1:0] sw_set,
  input  logic [NFLAG-1:0] sw_clr,
  input  logic [NFLAG-1:0] hw_clr,
  output logic [NFLAG-1:0] flags_q,
  output logic [NSRC-1:0]  req
);
  logic [NFLAG-1:0] set_v, flags_d;

  always_comb begin
    set_v        = '0;
    set_v[F_IE0] = ext_fall[0] | sw_set[F_IE0];
    set_v[F_TF0] = tmr_roll[0] | sw_set[F_TF0];
    set_v[F_IE1] = ext_fall[1] | sw_set[F_IE1];
    set_v[F_TF1] = tmr_roll[1] | sw_set[F_TF1];
    set_v[F_RX]  = rx_evt      | sw_set[F_RX];
    set_v[F_TX]  = tx_evt      | sw_set[F_TX];
    set_v[F_SPI] = spi_evt;
    set_v[F_CMP] = cmp_evt     | sw_set[F_CMP];
    set_v[F_GP +: NGP] = gp_evt;
    flags_d = (flags_q & ~(sw_clr | hw_clr)) | set_v;
    for (int e = 0; e < 2; e++) begin
      if (!ext_edge[e]) flags_d[2*e] = ~ext_lvl_n[e];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  always_comb begin
    req    = '0;
    req[0] = flags_q[F_IE0];
    req[1] = flags_q[F_TF0];
    req[2] = flags_q[F_IE1];
    req[3] = flags_q[F_TF1];
    req[4] = |flags_q[F_SPI:F_RX];
    req[5] = |flags_q[F_GP +: NGP];
    req[6] = flags_q[F_CMP];
  end

  assert_spi_no_swset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!flags_q[F_SPI] && sw_set[F_SPI] && !spi_evt) |=> !flags_q[F_SPI]);

  assert_gp_hw_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gp_evt == '0) |=> ((flags_q[F_GP +: NGP] & ~$past(flags_q[F_GP +: NGP])) == '0));
endmodule

// File: rtl/nic_nest.sv
module nic_nest
  import nic_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  lvl_t            push_lvl,
  input  logic            pop,
  output logic [NLVL-1:0] isr_q,
  output logic            act_any,
  output lvl_t            top_lvl
);
  logic [NLVL-1:0] isr_d;

  always_comb begin
    top_lvl = '0;
    for (int k = 0; k < NLVL; k++) begin
      if (isr_q[k]) top_lvl = lvl_t'(k);
    end
  end
  assign act_any = |isr_q;

  always_comb begin
    isr_d = isr_q;
    if (pop && act_any) isr_d[top_lvl] = 1'b0;
    if (push)           isr_d[push_lvl] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr_q <= '0;
    else        isr_q <= isr_d;
  end

  assert_reti_pops_one_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && act_any) |=> ($countones(isr_q) == $past($countones(isr_q)) - 1));
endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter
  import nic_pkg::*;
(
  input  logic [NSRC-1:0]  req,
  input  logic [NSRC-1:0]  src_en,
  input  logic             glb_en,
  input  logic [NPRIO-1:0] prio_lo,
  input  logic [NPRIO-1:0] prio_hi,
  input  logic             act_any,
  input  lvl_t             top_lvl,
  output logic             win_valid,
  output logic [IDXW-1:0]  win_idx,
  output lvl_t             win_lvl
);
  lvl_t lvl_a [NSRC];

  for (genvar g = 0; g < NSRC; g++) begin : g_lvl
    if (g < NPRIO) begin : g_prog
      assign lvl_a[g] = {prio_hi[g], prio_lo[g]};
    end else begin : g_fixed
      assign lvl_a[g] = '0;
    end
  end

  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_lvl   = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (req[i] && src_en[i] && glb_en && (!act_any || lvl_a[i] > top_lvl)
          && (!win_valid || lvl_a[i] > win_lvl)) begin
        win_valid = 1'b1;
        win_idx   = IDXW'(i);
        win_lvl   = lvl_a[i];
      end
    end
  end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instr_end,
  input  logic             irq_ack,
  input  logic             reti,
  input  logic             glb_en,
  input  logic [NSRC-1:0]  src_en,
  input  logic [NPRIO-1:0] prio_lo,
  input  logic [NPRIO-1:0] prio_hi,
  input  logic [1:0]       ext_mode,
  input  logic [1:0]       ext_pin_n,
  input  logic [1:0]       tmr_roll,
  input  logic             ser_rx_evt,
  input  logic             ser_tx_evt,
  input  logic             spi_evt,
  input  logic [NGP-1:0]   gp_evt,
  input  logic             cmp_evt,
  input  logic [NFLAG-1:0] sw_set,
  input  logic [NFLAG-1:0] sw_clr,
  output logic [NFLAG-1:0] flags,
  output logic             irq_take,
  output logic [VECW-1:0]  irq_vec
);
  logic [1:0]       lvl_n, fall;
  logic [NSRC-1:0]  req;
  logic [NFLAG-1:0] hw_clr;
  logic [NLVL-1:0]  isr;
  logic             act_any, win_valid, ack_eff;
  lvl_t             top_lvl, win_lvl;
  logic [IDXW-1:0]  win_idx;

  logic             wait_q, wait_d, take_q, take_d;
  logic [IDXW-1:0]  src_q;
  lvl_t             lvl_q;
  logic [VECW-1:0]  vec_q;

  for (genvar e = 0; e < 2; e++) begin : g_pin
    nic_pin_sync #(.STAGES(2)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_n(ext_pin_n[e]),
      .lvl_n(lvl_n[e]), .fall(fall[e]));
  end

  nic_flags u_flags (
    .clk(clk), .rst_n(rst_n), .ext_edge(ext_mode), .ext_lvl_n(lvl_n),
    .ext_fall(fall), .tmr_roll(tmr_roll), .rx_evt(ser_rx_evt),
    .tx_evt(ser_tx_evt), .spi_evt(spi_evt), .gp_evt(gp_evt),
    .cmp_evt(cmp_evt), .sw_set(sw_set), .sw_clr(sw_clr), .hw_clr(hw_clr),
    .flags_q(flags), .req(req));

  nic_nest u_nest (
    .clk(clk), .rst_n(rst_n), .push(ack_eff), .push_lvl(lvl_q), .pop(reti),
    .isr_q(isr), .act_any(act_any), .top_lvl(top_lvl));

  nic_arbiter u_arb (
    .req(req), .src_en(src_en), .glb_en(glb_en), .prio_lo(prio_lo),
    .prio_hi(prio_hi), .act_any(act_any), .top_lvl(top_lvl),
    .win_valid(win_valid), .win_idx(win_idx), .win_lvl(win_lvl));

  assign ack_eff = irq_ack & wait_q;

  always_comb begin
    hw_clr = '0;
    if (ack_eff) begin
      case (src_q)
        IDXW'(0): hw_clr[F_IE0] = ext_mode[0];
        IDXW'(1): hw_clr[F_TF0] = 1'b1;
        IDXW'(2): hw_clr[F_IE1] = ext_mode[1];
        IDXW'(3): hw_clr[F_TF1] = 1'b1;
        default:  hw_clr = '0;
      endcase
    end
    take_d = !wait_q && instr_end && win_valid;
    wait_d = take_d || (wait_q && !irq_ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= 1'b0;
      take_q <= 1'b0;
    end else begin
      wait_q <= wait_d;
      take_q <= take_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      lvl_q <= '0;
      vec_q <= '0;
    end else if (take_d) begin
      src_q <= win_idx;
      lvl_q <= win_lvl;
      vec_q <= vec_of(win_idx);
    end
  end

  assign irq_take = take_q;
  assign irq_vec  = vec_q;

  assert_take_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> !irq_take);

  assert_take_at_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> $past(instr_end));

  assert_strict_preempt_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> (!act_any || lvl_q > top_lvl));

  assert_lvl3_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (isr[3] && !reti) |=> !irq_take);
endmodule

// File: tb/nest_irq_ctrl_tb_top.sv
module nest_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, instr_end, irq_ack, reti, glb_en, ser_rx_evt, ser_tx_evt, spi_evt, cmp_evt;
  logic [6:0]  src_en;
  logic [5:0]  prio_lo, prio_hi;
  logic [1:0]  ext_mode, ext_pin_n, tmr_roll;
  logic [7:0]  gp_evt;
  logic [15:0] sw_set, sw_clr, flags, irq_vec;
  logic        irq_take;
  int          checks = 0, errors = 0;

  always #2 clk = ~clk;

  nest_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .instr_end(instr_end), .irq_ack(irq_ack), .reti(reti),
    .glb_en(glb_en), .src_en(src_en), .prio_lo(prio_lo), .prio_hi(prio_hi),
    .ext_mode(ext_mode), .ext_pin_n(ext_pin_n), .tmr_roll(tmr_roll),
    .ser_rx_evt(ser_rx_evt), .ser_tx_evt(ser_tx_evt), .spi_evt(spi_evt),
    .gp_evt(gp_evt), .cmp_evt(cmp_evt), .sw_set(sw_set), .sw_clr(sw_clr),
    .flags(flags), .irq_take(irq_take), .irq_vec(irq_vec));

  // ---------------- behavioural reference model ----------------
  logic [1:0]  m_s1, m_s2, m_s3;
  logic [15:0] m_fl, m_vec;
  logic [3:0]  m_isr;
  logic        m_wait, m_take;
  int          m_src, m_lvl;

  function automatic bit m_req(input int i, input logic [15:0] f);
    case (i)
      0: return f[0];
      1: return f[1];
      2: return f[2];
      3: return f[3];
      4: return f[4] | f[5] | f[6];
      5: return |f[15:8];
      default: return f[7];
    endcase
  endfunction

  function automatic int m_level(input int i);
    if (i >= 6) return 0;
    return 2 * int'(prio_hi[i]) + int'(prio_lo[i]);
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    logic [15:0] nf;
    logic [3:0]  ni;
    int top, best, bl;
    if (!rst_n) begin
      m_s1 = 2'b11; m_s2 = 2'b11; m_s3 = 2'b11;
      m_fl = '0; m_isr = '0; m_wait = 0; m_take = 0; m_vec = '0; m_src = 0; m_lvl = 0;
    end else begin
      nf = m_fl & ~sw_clr;
      if (irq_ack && m_wait) begin
        if (m_src == 1 || m_src == 3 || (m_src == 0 && ext_mode[0]) || (m_src == 2 && ext_mode[1]))
          nf[m_src] = 1'b0;
      end
      nf = nf | (sw_set & 16'h00BF);
      if (tmr_roll[0]) nf[1] = 1'b1;
      if (tmr_roll[1]) nf[3] = 1'b1;
      if (ser_rx_evt)  nf[4] = 1'b1;
      if (ser_tx_evt)  nf[5] = 1'b1;
      if (spi_evt)     nf[6] = 1'b1;
      if (cmp_evt)     nf[7] = 1'b1;
      nf[15:8] = nf[15:8] | gp_evt;
      for (int e = 0; e < 2; e++) begin
        if (ext_mode[e]) begin
          if (m_s3[e] && !m_s2[e]) nf[2*e] = 1'b1;
        end else nf[2*e] = !m_s2[e];
      end
      ni = m_isr; top = -1;
      for (int k = 0; k < 4; k++) if (m_isr[k]) top = k;
      if (reti && top >= 0) ni[top] = 1'b0;
      if (irq_ack && m_wait) ni[m_lvl] = 1'b1;
      best = -1; bl = 0;
      if (!m_wait && instr_end && glb_en) begin
        for (int lv = 3; lv >= 0; lv--) begin
          for (int i = 0; i < 7; i++) begin
            if (best < 0 && m_req(i, m_fl) && src_en[i] && m_level(i) == lv && lv > top) begin
              best = i; bl = lv;
            end
          end
        end
      end
      m_take = (best >= 0);
      if (m_wait && irq_ack) m_wait = 0;
      else if (best >= 0) begin
        m_wait = 1; m_src = best; m_lvl = bl; m_vec = 16'h0003 + 16'(8 * best);
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_pin_n;
      m_fl = nf; m_isr = ni;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (irq_take !== m_take || (m_take && irq_vec !== m_vec)) begin
        errors++;
        $display("FAIL R10 model take/vec act=%0b/%h exp=%0b/%h", irq_take, irq_vec, m_take, m_vec);
      end
      checks++;
      if (flags !== m_fl) begin
        errors++;
        $display("FAIL R6 model flags act=%h exp=%h", flags, m_fl);
      end
    end
  end

  // ---------------- directed checks ----------------
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic boundary_expect(input bit take, input logic [15:0] vec, input string tag);
    instr_end = 1; step(1); instr_end = 0;
    chk(irq_take == take, tag, 32'(irq_take), 32'(take));
    if (take) chk(irq_vec == vec, tag, 32'(irq_vec), 32'(vec));
  endtask

  task automatic ack_it;
    irq_ack = 1; step(1); irq_ack = 0;
  endtask

  task automatic reti_it;
    reti = 1; step(1); reti = 0;
  endtask

  task automatic sset(input int b);
    sw_set[b] = 1'b1; step(1); sw_set = '0;
  endtask

  task automatic sclr(input int b);
    sw_clr[b] = 1'b1; step(1); sw_clr = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; instr_end = 0; irq_ack = 0; reti = 0; glb_en = 0; src_en = '0;
    prio_lo = '0; prio_hi = '0; ext_mode = 2'b11; ext_pin_n = 2'b11; tmr_roll = '0;
    ser_rx_evt = 0; ser_tx_evt = 0; spi_evt = 0; gp_evt = '0; cmp_evt = 0;
    sw_set = '0; sw_clr = '0;
    step(3); rst_n = 1; step(1);
    chk(flags == 16'h0, "R1 reset flags", 32'(flags), 0);
    chk(irq_take == 1'b0, "R1 reset take", 32'(irq_take), 0);
    glb_en = 1; src_en = 7'h7F;
    boundary_expect(0, 16'h0, "R1 nothing pending");

    // R6 software set, R9 vector, R10 pulse and hold, R4 hardware clear
    sset(1);
    chk(flags[1] == 1'b1, "R6 sw set TF0", 32'(flags[1]), 1);
    boundary_expect(1, 16'h000B, "R9 T0 vector");
    step(1);
    chk(irq_take == 1'b0, "R10 single pulse", 32'(irq_take), 0);
    sset(7);
    boundary_expect(0, 16'h0, "R10 no take before ack");
    ack_it;
    chk(flags[1] == 1'b0, "R4 timer flag cleared on ack", 32'(flags[1]), 0);
    reti_it;
    sclr(7);
    chk(flags[7] == 1'b0, "R6 sw clear CF", 32'(flags[7]), 0);

    // R4 rollover
    tmr_roll[1] = 1; step(1); tmr_roll = '0;
    chk(flags[3] == 1'b1, "R4 rollover sets TF1", 32'(flags[3]), 1);
    sclr(3);

    // R2 edge mode
    ext_pin_n[0] = 0; step(2);
    chk(flags[0] == 1'b0, "R2 not before third edge", 32'(flags[0]), 0);
    step(1);
    chk(flags[0] == 1'b1, "R2 set on third edge", 32'(flags[0]), 1);
    ext_pin_n[0] = 1; step(4);
    chk(flags[0] == 1'b1, "R2 flag held", 32'(flags[0]), 1);
    boundary_expect(1, 16'h0003, "R9 INT0 vector");
    ack_it;
    chk(flags[0] == 1'b0, "R2 cleared on ack", 32'(flags[0]), 0);
    reti_it;

    // R3 level mode
    ext_mode[1] = 0; ext_pin_n[1] = 0; step(3);
    chk(flags[2] == 1'b1, "R3 follows pin", 32'(flags[2]), 1);
    sclr(2);
    chk(flags[2] == 1'b1, "R3 sw clear ignored", 32'(flags[2]), 1);
    boundary_expect(1, 16'h0013, "R9 INT1 vector");
    ack_it;
    chk(flags[2] == 1'b1, "R3 ack leaves flag", 32'(flags[2]), 1);
    reti_it;
    ext_pin_n[1] = 1; step(3);
    chk(flags[2] == 1'b0, "R3 pin released", 32'(flags[2]), 0);

    // R5 / R6 group flags
    sset(6);
    chk(flags[6] == 1'b0, "R6 SPI not sw settable", 32'(flags[6]), 0);
    spi_evt = 1; step(1); spi_evt = 0;
    chk(flags[6] == 1'b1, "R5 SPI event", 32'(flags[6]), 1);
    boundary_expect(1, 16'h0023, "R5 serial vector");
    ack_it;
    chk(flags[6] == 1'b1, "R5 SPI kept after ack", 32'(flags[6]), 1);
    reti_it;
    sclr(6);
    sset(9);
    chk(flags[9] == 1'b0, "R6 GP not sw settable", 32'(flags[9]), 0);
    gp_evt = 8'h02; step(1); gp_evt = '0;
    chk(flags[9] == 1'b1, "R5 GP event", 32'(flags[9]), 1);
    boundary_expect(1, 16'h002B, "R5 general vector");
    ack_it;
    chk(flags[9] == 1'b1, "R5 GP kept after ack", 32'(flags[9]), 1);
    reti_it;
    sclr(9);

    // R7 enables
    sset(1);
    glb_en = 0;
    boundary_expect(0, 16'h0, "R7 global disable");
    glb_en = 1; src_en[1] = 0;
    boundary_expect(0, 16'h0, "R7 source disable");
    src_en = 7'h7F;

    // R8 / R11 / R12 nesting
    sset(7); sset(4);
    prio_hi[4] = 1;
    boundary_expect(1, 16'h0023, "R8 level 2 wins");
    ack_it;
    boundary_expect(0, 16'h0, "R11 lower level blocked");
    prio_hi[3] = 1; sset(3);
    boundary_expect(0, 16'h0, "R11 equal level blocked");
    prio_lo[3] = 1;
    boundary_expect(1, 16'h001B, "R11 higher level preempts");
    ack_it;
    chk(flags[3] == 1'b0, "R4 TF1 cleared on ack", 32'(flags[3]), 0);
    prio_lo[4] = 1;
    boundary_expect(0, 16'h0, "R11 level 3 not preempted");
    reti_it;
    boundary_expect(1, 16'h0023, "R12 pop re-opens level 3");
    ack_it; reti_it; reti_it; reti_it;
    sclr(4);
    prio_lo = '0; prio_hi = '0;
    boundary_expect(1, 16'h000B, "R9 tie lower index");
    ack_it; reti_it;
    boundary_expect(1, 16'h0033, "R9 comparator vector");
    ack_it;
    sset(1); prio_lo[1] = 1;
    boundary_expect(1, 16'h000B, "R8 comparator is level 0");
    ack_it; reti_it; reti_it;
    sclr(7);
    step(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule